// File: doc/BRIEF.md
# Reference-Period Edge Counting Phase Detector

This block measures how many rising edges of a fast oscillator clock fall within one period of a slow reference clock. It compares that number against a fixed multiplication target and reports the signed difference. It is the measuring front end of a digital frequency-locking loop. A loop filter consumes the error word each time the ready strobe pulses, and a lock monitor can watch the sign and low magnitude bits.

All logic runs in the oscillator clock domain. The reference clock passes through a multi-flop synchronizer, and a rising edge of the synchronized copy marks each period boundary. At a boundary, the running count is turned into an error word that is held until the next boundary, and counting starts again. The oscillator edge that coincides with the boundary is already counted as the first edge of the new period.

The reset is asynchronous and active low, and its release is synchronized to the oscillator clock inside the block. The first boundary after reset only arms the measurement, because the period before it is partial. If the reference stops, the counter holds at its maximum value instead of wrapping.

Top module: `refper_phase_det`

## Requirements
- R1: While reset is asserted, and after it until the first reported measurement, err_val is 0, err_stb is 0, err_sign is 0 and err_mag_lo is 0.
- R2: A period boundary is a rising edge of ref_clk, seen through a two-flop synchronizer. If the first oscillator rising edge that samples ref_clk high is edge k, err_stb is high in the cycle after edge k+2 and low in the cycle after edge k+1.
- R3: The measured count is the number of oscillator rising edges from one boundary edge up to, but not including, the next. err_val is the 17-bit two's-complement value 512 minus that count, so a slow oscillator gives a positive value.
- R4: err_stb is high for exactly one oscillator cycle per reported boundary. err_val keeps its value in every cycle where err_stb is low.
- R5: The first boundary after reset release produces no strobe and leaves err_val unchanged. Every later boundary produces a strobe.
- R6: The 16-bit edge counter saturates at 65535. A reference period longer than that reports 512 - 65535 = -65023.
- R7: err_sign is bit 16 of err_val: 1 when the oscillator runs fast (negative error), 0 otherwise.
- R8: err_mag_lo holds bits 3:0 of the absolute value of err_val.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Fast oscillator clock being measured; clocks all logic |
| arst_n | input | 1 | Asynchronous active-low reset, release synchronized internally |
| ref_clk | input | 1 | Slow reference clock, asynchronous to osc_clk |
| err_val | output | 17 | Signed error: target count minus measured count |
| err_stb | output | 1 | One-cycle pulse when err_val carries a new measurement |
| err_sign | output | 1 | 1 when the error is negative (oscillator fast) |
| err_mag_lo | output | 4 | Low four bits of the error magnitude |

## Verification
A reference rising edge driven ahead of oscillator edge k reaches the outputs after three register stages: two synchronizer flops and one result register. The strobe and the new error, sign and magnitude are therefore sampled in the cycle after edge k+2. The bench drives ref_clk on falling edges and counts falling edges from the one where the edge is driven. It reads the result on the third of them, checks that the strobe is still low on the second, and checks on the fourth that the strobe has dropped and the error has held. Each result belongs to the period that ends at the edge just driven, so the bench compares against the expected value of the previous table row.

// File: rtl/prd_pkg.sv
package prd_pkg;
  localparam int DEF_CNT_W     = 16;
  localparam int DEF_TARGET    = 512;
  localparam int DEF_SYNC_STGS = 2;
  localparam int DEF_OBS_W     = 4;
endpackage

// File: rtl/prd_rst_sync.sv
module prd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sr_q <= '0;
    else         sr_q <= sr_d;
  end

  assign rst_n = sr_q[STAGES-1];
endmodule

// File: rtl/prd_ref_sync.sv
module prd_ref_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_async,
  output logic boundary
);
  logic [STAGES-1:0] stg_q;
  logic              prev_q;
  logic              prev_d;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic stg_d;
      if (g == 0) begin : g_first
        always_comb stg_d = ref_async;
      end else begin : g_next
        always_comb stg_d = stg_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= 1'b0;
        else        stg_q[g] <= stg_d;
      end
    end
  endgenerate

  always_comb prev_d = stg_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign boundary = stg_q[STAGES-1] & ~prev_q;

  AST_BOUNDARY_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> !boundary); // R2
endmodule

// File: rtl/prd_period_cnt.sv
module prd_period_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boundary,
  output logic             meas_vld,
  output logic [CNT_W-1:0] meas_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             cnt_en;

  always_comb begin
    cnt_en  = boundary | (cnt_q != CNT_MAX);
    cnt_d   = cnt_q;
    armed_d = armed_q;
    if (boundary) begin
      cnt_d   = CNT_ONE;
      armed_d = 1'b1;
    end else if (cnt_en) begin
      cnt_d = cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign meas_vld = boundary & armed_q;
  assign meas_cnt = cnt_q;

  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !boundary) |=> (cnt_q == CNT_MAX)); // R6
  AST_FIRST_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !armed_q) |=> (armed_q && cnt_q == CNT_ONE)); // R5
endmodule

// File: rtl/prd_err_calc.sv
module prd_err_calc #(
  parameter int CNT_W  = 16,
  parameter int TARGET = 512,
  parameter int OBS_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    meas_vld,
  input  logic [CNT_W-1:0]        meas_cnt,
  output logic signed [CNT_W:0]   err,
  output logic                    stb,
  output logic                    sign,
  output logic [OBS_W-1:0]        mag_lo
);
  localparam int EW = CNT_W + 1;
  localparam logic signed [EW-1:0] TGT_S = EW'(TARGET);

  logic signed [EW-1:0] err_q, err_d;
  logic                 stb_q, stb_d;
  logic signed [EW-1:0] meas_s;
  logic        [EW-1:0] err_abs;

  always_comb begin
    meas_s = $signed({1'b0, meas_cnt});
    err_d  = err_q;
    stb_d  = 1'b0;
    if (meas_vld) begin
      err_d = TGT_S - meas_s;
      stb_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
      stb_q <= 1'b0;
    end else begin
      if (meas_vld) err_q <= err_d;
      stb_q <= stb_d;
    end
  end

  always_comb begin
    err_abs = err_q[EW-1] ? EW'(-err_q) : EW'(err_q);
  end

  assign err    = err_q;
  assign stb    = stb_q;
  assign sign   = err_q[EW-1];
  assign mag_lo = err_abs[OBS_W-1:0];

  AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q); // R4
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_q |-> $stable(err_q)); // R4
endmodule

// File: rtl/refper_phase_det.sv
module refper_phase_det #(
  parameter int CNT_W     = prd_pkg::DEF_CNT_W,
  parameter int TARGET    = prd_pkg::DEF_TARGET,
  parameter int SYNC_STGS = prd_pkg::DEF_SYNC_STGS,
  parameter int OBS_W     = prd_pkg::DEF_OBS_W
) (
  input  logic                  osc_clk,
  input  logic                  arst_n,
  input  logic                  ref_clk,
  output logic signed [CNT_W:0] err_val,
  output logic                  err_stb,
  output logic                  err_sign,
  output logic [OBS_W-1:0]      err_mag_lo
);
  logic             rst_n;
  logic             boundary;
  logic             meas_vld;
  logic [CNT_W-1:0] meas_cnt;

  prd_rst_sync #(.STAGES(2)) u_rst (
    .clk    (osc_clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  prd_ref_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk       (osc_clk),
    .rst_n     (rst_n),
    .ref_async (ref_clk),
    .boundary  (boundary)
  );

  prd_period_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (osc_clk),
    .rst_n    (rst_n),
    .boundary (boundary),
    .meas_vld (meas_vld),
    .meas_cnt (meas_cnt)
  );

  prd_err_calc #(.CNT_W(CNT_W), .TARGET(TARGET), .OBS_W(OBS_W)) u_err (
    .clk      (osc_clk),
    .rst_n    (rst_n),
    .meas_vld (meas_vld),
    .meas_cnt (meas_cnt),
    .err      (err_val),
    .stb      (err_stb),
    .sign     (err_sign),
    .mag_lo   (err_mag_lo)
  );
endmodule

// File: tb/test_refper_phase_det.sv
`timescale 1ns/1ps
module test_refper_phase_det;
  typedef struct packed {
    int period;
    int exp_err;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{512, 0}, '{500, 12}, '{520, -8}, '{8, 504},
    '{1000, -488}, '{513, -1}, '{511, 1}, '{64, 448}
  };

  logic               osc_clk;
  logic               arst_n;
  logic               ref_clk;
  logic signed [16:0] err_val;
  logic               err_stb;
  logic               err_sign;
  logic [3:0]         err_mag_lo;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  refper_phase_det i_refper_phase_det (
    .osc_clk    (osc_clk),
    .arst_n     (arst_n),
    .ref_clk    (ref_clk),
    .err_val    (err_val),
    .err_stb    (err_stb),
    .err_sign   (err_sign),
    .err_mag_lo (err_mag_lo)
  );

  initial osc_clk = 1'b0;
  always #2.5 osc_clk = ~osc_clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_outputs(input int e, input string tag);
    int mag;
    mag = (e < 0 ? -e : e) & 15;
    chk(int'(err_val) == e, {tag, " R3 err_val"}, int'(err_val), e);
    chk(err_sign == (e < 0), {tag, " R7 err_sign"}, int'(err_sign), int'(e < 0));
    chk(int'(err_mag_lo) == mag, {tag, " R8 err_mag_lo"}, int'(err_mag_lo), mag);
  endtask

  // Drive one reference rising edge now (at a falling edge), keep the period p,
  // and check the result for the period that ends at this edge.
  task automatic ref_period(input int p, input bit exp_stb, input int exp_e, input string tag);
    int held;
    held = int'(err_val);
    ref_clk = 1'b1;
    for (int i = 1; i <= p; i++) begin
      @(negedge osc_clk);
      if (i == 2) chk(err_stb == 1'b0, {tag, " R2 strobe early"}, int'(err_stb), 0);
      if (i == 3) begin
        if (exp_stb) begin
          chk(err_stb == 1'b1, {tag, " R2 strobe due"}, int'(err_stb), 1);
          chk_outputs(exp_e, tag);
        end else begin
          chk(err_stb == 1'b0, {tag, " R5 first boundary silent"}, int'(err_stb), 0);
          chk(int'(err_val) == held, {tag, " R5 err unchanged"}, int'(err_val), held);
        end
      end
      if (i == 4 && exp_stb) begin
        chk(err_stb == 1'b0, {tag, " R4 strobe one cycle"}, int'(err_stb), 0);
        chk(int'(err_val) == exp_e, {tag, " R4 err held"}, int'(err_val), exp_e);
      end
      if (i == p / 2) ref_clk = 1'b0;
    end
  endtask

  initial begin
    int prev_err;
    arst_n  = 1'b0;
    ref_clk = 1'b0;
    repeat (3) @(negedge osc_clk);
    // R1: reset state
    chk(err_stb == 1'b0, "R1 reset strobe", int'(err_stb), 0);
    chk_outputs(0, "R1 reset");
    arst_n = 1'b1;
    repeat (5) @(negedge osc_clk);
    chk(err_stb == 1'b0, "R1 after release strobe", int'(err_stb), 0);

    // R5: first boundary arms only
    ref_period(VECS[0].period, 1'b0, 0, "R5 first");
    prev_err = VECS[0].exp_err;
    // table walk: each edge reports the previous row's period
    for (int k = 1; k < NV; k++) begin
      ref_period(VECS[k].period, 1'b1, prev_err, $sformatf("vec%0d", k));
      prev_err = VECS[k].exp_err;
    end
    ref_period(16, 1'b1, prev_err, "vec_last");

    // R6: saturation with reference absent for more than 65535 cycles
    ref_period(70000, 1'b1, 512 - 16, "R6 pre");
    ref_period(16, 1'b1, 512 - 65535, "R6 saturate");

    // R1/R5: reset mid-operation, then re-arm
    arst_n = 1'b0;
    #1;
    chk(err_stb == 1'b0, "R1 mid reset strobe", int'(err_stb), 0);
    chk_outputs(0, "R1 mid reset");
    @(negedge osc_clk);
    arst_n = 1'b1;
    repeat (5) @(negedge osc_clk);
    ref_period(600, 1'b0, 0, "R5 rearm");
    ref_period(16, 1'b1, 512 - 600, "R3 after rearm");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < 190000; c++) @(posedge osc_clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule